// File: doc/BRIEF.md
# Absolute-Target Next Program Counter Unit

This block decides where a single-cycle core fetches next. It receives the current 8-bit program counter, a 3-bit code for the kind of control transfer the decoder found, the 8-bit immediate of the instruction, the 16-bit value of the register that a conditional branch tests, and a halt signal. From these it produces the next program counter, a link value for jump-and-link, and a flag that says a transfer took place. The logic is purely combinational. The core's own PC register samples `next_pc_o` at each clock edge.

Transfer targets are absolute. The immediate is zero-extended and loaded into the PC as it stands, with no offset added to the current PC. There are four conditional branches, and each compares one register against zero: equal to zero, not equal to zero, negative, or strictly positive. The register is read as two's complement. While halt is asserted the PC holds its value, so fetching freezes on the current instruction.

Top module: `absbr_next_pc`

## Requirements
- R1: With flow code 0 (sequential) or the reserved code 7, and halt low, `next_pc_o` is `pc_i`+1 and `taken_o` is 0.
- R2: The PC increment wraps, so a sequential step from 255 yields 0.
- R3: With flow code 1 (jump) and halt low, `next_pc_o` equals `imm_i` zero-extended and `taken_o` is 1. No part of `pc_i` is added.
- R4: With flow code 2 (jump-and-link) and halt low, `next_pc_o` equals `imm_i` and `taken_o` is 1. `link_o` carries `pc_i`+1 so that the caller can write it to the link register.
- R5: Flow code 3 (branch-if-zero) is taken exactly when `reg_val_i` equals 0.
- R6: Flow code 4 (branch-if-nonzero) is taken exactly when `reg_val_i` is not 0.
- R7: Flow code 5 (branch-if-negative) is taken exactly when bit 15 of `reg_val_i` is set.
- R8: Flow code 6 (branch-if-positive) is taken exactly when bit 15 is clear and the value is nonzero. Zero does not count as positive.
- R9: While `halt_i` is 1, `next_pc_o` equals `pc_i` and `taken_o` is 0, whatever the flow code.
- R10: `link_o` equals `pc_i`+1, with wrap, for every flow code and halt value.

For R5 to R8: when the branch is taken, `next_pc_o` is `imm_i`. When it is not taken, `next_pc_o` is `pc_i`+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 8 | Current program counter |
| flow_i | input | 3 | Transfer kind: 0 seq, 1 jump, 2 jump-and-link, 3 zero, 4 nonzero, 5 negative, 6 positive, 7 reserved |
| imm_i | input | 8 | Absolute target from the instruction |
| reg_val_i | input | 16 | Value of the tested register |
| halt_i | input | 1 | Freeze request |
| next_pc_o | output | 8 | PC for the next fetch |
| link_o | output | 8 | Return address, current PC plus one |
| taken_o | output | 1 | A transfer replaced the sequential step |

## Verification
Halt and a transfer whose condition holds can arrive in the same cycle. The same goes for a sequential step and the wrap at address 255, which can also coincide with a jump-and-link whose link value wraps. The sweep drives every PC against every flow code, both halt levels, and tested values that sit on the sign and zero boundaries. That combination provokes each of these collisions. The outcome is judged against the rule that halt overrides everything and that the link value keeps wrapping even while frozen.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int unsigned PC_W   = 8;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned FLOW_W = 3;

  typedef enum logic [FLOW_W-1:0] {
    FLOW_SEQ  = 3'd0,
    FLOW_JMP  = 3'd1,
    FLOW_JAL  = 3'd2,
    FLOW_BZ   = 3'd3,
    FLOW_BNZ  = 3'd4,
    FLOW_BNEG = 3'd5,
    FLOW_BPOS = 3'd6,
    FLOW_RSV  = 3'd7
  } flow_e;
endpackage

// File: rtl/npc_incr.sv
module npc_incr #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] pc_i,
  output logic [W-1:0] pc_inc_o,
  output logic         wrap_o
);
  function automatic logic [W-1:0] plus_one(input logic [W-1:0] v);
    return v + W'(1);
  endfunction

  assign pc_inc_o = plus_one(pc_i);
  assign wrap_o   = &pc_i;

  always_comb begin
    if (wrap_o) begin
      assert_wrap_zero_R2: assert (pc_inc_o == '0);
    end
  end
endmodule

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
  import npc_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  flow_e         flow_i,
  input  logic [DW-1:0] val_i,
  output logic          is_zero_o,
  output logic          is_neg_o,
  output logic          taken_o
);
  function automatic logic decide(input flow_e f, input logic z, input logic n);
    case (f)
      FLOW_JMP, FLOW_JAL: return 1'b1;
      FLOW_BZ:            return z;
      FLOW_BNZ:           return !z;
      FLOW_BNEG:          return n;
      FLOW_BPOS:          return !n && !z;
      default:            return 1'b0;
    endcase
  endfunction

  assign is_zero_o = (val_i == '0);
  assign is_neg_o  = val_i[DW-1];
  assign taken_o   = decide(flow_i, is_zero_o, is_neg_o);

  always_comb begin
    if (flow_i == FLOW_BPOS && taken_o) begin
      assert_pos_excl_zero_R8: assert (!is_zero_o && !is_neg_o);
    end
    if (flow_i == FLOW_SEQ || flow_i == FLOW_RSV) begin
      assert_seq_not_taken_R1: assert (!taken_o);
    end
  end
endmodule

// File: rtl/npc_target_sel.sv
module npc_target_sel #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] pc_i,
  input  logic [W-1:0] pc_inc_i,
  input  logic [W-1:0] target_i,
  input  logic         take_i,
  input  logic         halt_i,
  output logic [W-1:0] next_o
);
  always_comb begin
    if (halt_i)      next_o = pc_i;
    else if (take_i) next_o = target_i;
    else             next_o = pc_inc_i;
  end
endmodule

// File: rtl/absbr_next_pc.sv
module absbr_next_pc
  import npc_pkg::*;
#(
  parameter int unsigned PCW = PC_W,
  parameter int unsigned DW  = DATA_W
) (
  input  logic [PCW-1:0]    pc_i,
  input  logic [FLOW_W-1:0] flow_i,
  input  logic [PCW-1:0]    imm_i,
  input  logic [DW-1:0]     reg_val_i,
  input  logic              halt_i,
  output logic [PCW-1:0]    next_pc_o,
  output logic [PCW-1:0]    link_o,
  output logic              taken_o
);
  flow_e          flow_w;
  logic [PCW-1:0] pc_inc_w;
  logic           wrap_w;
  logic           is_zero_w;
  logic           is_neg_w;
  logic           cond_taken_w;
  logic           eff_taken_w;
  logic [PCW-1:0] target_w;

  assign flow_w      = flow_e'(flow_i);
  assign target_w    = imm_i;
  assign eff_taken_w = cond_taken_w && !halt_i;

  npc_incr #(.W(PCW)) u_incr (
    .pc_i     (pc_i),
    .pc_inc_o (pc_inc_w),
    .wrap_o   (wrap_w)
  );

  npc_cond_eval #(.DW(DW)) u_cond (
    .flow_i    (flow_w),
    .val_i     (reg_val_i),
    .is_zero_o (is_zero_w),
    .is_neg_o  (is_neg_w),
    .taken_o   (cond_taken_w)
  );

  npc_target_sel #(.W(PCW)) u_sel (
    .pc_i     (pc_i),
    .pc_inc_i (pc_inc_w),
    .target_i (target_w),
    .take_i   (eff_taken_w),
    .halt_i   (halt_i),
    .next_o   (next_pc_o)
  );

  assign link_o  = pc_inc_w;
  assign taken_o = eff_taken_w;

  always_comb begin
    if (halt_i) begin
      assert_halt_freeze_R9: assert (next_pc_o == pc_i && !taken_o);
    end
    if (!halt_i && (flow_w == FLOW_JMP || flow_w == FLOW_JAL)) begin
      assert_jump_abs_R3: assert (taken_o && next_pc_o == imm_i);
    end
    if (!halt_i && !taken_o) begin
      assert_fallthrough_R1: assert (next_pc_o == link_o);
    end
    if (wrap_w) begin
      assert_link_wrap_R10: assert (link_o == '0);
    end
    if (!halt_i && flow_w == FLOW_BZ) begin
      assert_bz_R5: assert (taken_o == is_zero_w);
    end
    if (!halt_i && flow_w == FLOW_BNEG) begin
      assert_bneg_R7: assert (taken_o == is_neg_w);
    end
  end
endmodule

// File: tb/tb_absbr_next_pc.sv
module tb_absbr_next_pc;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic [7:0]  pc;
  logic [2:0]  flow;
  logic [7:0]  imm;
  logic [15:0] rv;
  logic        halt;
  logic [7:0]  next_pc;
  logic [7:0]  link;
  logic        taken;

  int applied = 0;
  int miscmp  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  absbr_next_pc dut (
    .pc_i      (pc),
    .flow_i    (flow),
    .imm_i     (imm),
    .reg_val_i (rv),
    .halt_i    (halt),
    .next_pc_o (next_pc),
    .link_o    (link),
    .taken_o   (taken)
  );

  function automatic logic [15:0] pick_val(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h0002;
      3: return 16'h7FFF;
      4: return 16'h8000;
      5: return 16'h8001;
      6: return 16'hFFFF;
      7: return 16'h0100;
      8: return 16'h00FF;
      default: return 16'h4000;
    endcase
  endfunction

  function automatic logic [7:0] pick_imm(input int i);
    case (i)
      0: return 8'h00;
      1: return 8'h5A;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic string req_of(input int f, input bit h, input int p);
    if (h) return "R9";
    case (f)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      6: return "R8";
      default: return (p == 255) ? "R2" : "R1";
    endcase
  endfunction

  task automatic check_one(input int p, input int f, input int iv, input int sv, input bit h);
    int  signed_v;
    bit  cond;
    int  exp_next;
    int  exp_link;
    bit  exp_taken;
    signed_v = int'($signed(rv));
    case (f)
      1, 2: cond = 1'b1;
      3:    cond = (signed_v == 0);
      4:    cond = (signed_v != 0);
      5:    cond = (signed_v < 0);
      6:    cond = (signed_v > 0);
      default: cond = 1'b0;
    endcase
    exp_link  = (p + 1) % 256;
    exp_taken = cond && !h;
    if (h)              exp_next = p;
    else if (exp_taken) exp_next = int'(imm);
    else                exp_next = exp_link;
    applied++;
    if (int'(next_pc) != exp_next || taken != exp_taken) begin
      miscmp++;
      $display("FAIL %s pc=%0d flow=%0d val=%h halt=%0d: next=%0d taken=%0d expected next=%0d taken=%0d",
               req_of(f, h, p), p, f, rv, h, next_pc, taken, exp_next, exp_taken);
    end else if (int'(link) != exp_link) begin
      miscmp++;
      $display("FAIL R10 pc=%0d flow=%0d: link=%0d expected %0d", p, f, link, exp_link);
    end
    if (iv < 0 || sv < 0) miscmp++;
  endtask

  initial begin
    pc = '0; flow = '0; imm = '0; rv = '0; halt = 1'b0;
    // Sweep covering R1 R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int h = 0; h < 2; h++) begin
      for (int f = 0; f < 8; f++) begin
        for (int sv = 0; sv < 10; sv++) begin
          for (int iv = 0; iv < 3; iv++) begin
            for (int p = 0; p < 256; p++) begin
              @(posedge clk);
              pc = 8'(p); flow = 3'(f); imm = pick_imm(iv);
              rv = pick_val(sv); halt = h[0];
              @(negedge clk);
              check_one(p, f, iv, sv, h[0]);
            end
          end
        end
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      miscmp++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
      $finish;
    end
  end
endmodule